// File: doc/BRIEF.md
# MUX recirculation bus synchronizer

This block carries a multi-bit data word from a source clock domain into an unrelated destination clock domain. Only one control bit crosses the boundary through synchronizer flops. The data bits are never synchronized one by one.

On the source side a load strobe captures the word into a holding register and raises an enable qualifier. That qualifier is the only signal that passes through a chain of destination flops. The synchronized qualifier drives the select of a two-input multiplexer in front of every destination data flop. While the select is low, each flop reloads its own output. While it is high, each flop takes the held source word. The source keeps the word frozen for the whole time the qualifier is high, so every destination bit flips in the same destination cycle.

A source busy flag blocks new words. It covers the time the qualifier is high and a following idle gap, which lets the destination see the qualifier fall before the next word. The integrator sets the hold and gap lengths, in source cycles, so that each spans at least three destination cycles.

Top module: `mux_recirc_bus_sync`

## Requirements
- R1: When `src_load` is high at a source rising edge and `src_busy` is low, the word on `src_data` is captured and `src_busy` reads 1 after that edge.
- R2: A `src_load` while `src_busy` is high is ignored. The word later presented on `dst_data` stays the one accepted earlier.
- R3: After an accepted load the internal enable stays high for exactly HOLD_CYCLES source cycles. `src_busy` stays high for HOLD_CYCLES+GAP_CYCLES source cycles and then returns to 0.
- R4: `dst_data` changes only in a destination cycle that follows a cycle in which the synchronized enable is high. It then takes the whole accepted word at once and never shows a mix of old and new bits.
- R5: `dst_valid` is a one-destination-cycle pulse. It rises in the same cycle that `dst_data` first shows a new word, after the (SYNC_STAGES+1)-th destination rising edge that follows the accepting source edge.
- R6: `src_rst` and `dst_rst` are independent, synchronous and active high. `src_rst` clears `src_busy` and the held word. `dst_rst` clears `dst_data`, `dst_valid` and the synchronizer stages.
- R7: Each accepted word yields exactly one `dst_valid` pulse. Words arrive in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source synchronous reset, active high |
| src_load | input | 1 | Request to send `src_data` |
| src_data | input | DATA_W | Word to transfer |
| src_busy | output | 1 | High while a transfer and its idle gap are in progress |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination synchronous reset, active high |
| dst_data | output | DATA_W | Transferred word, held between transfers |
| dst_valid | output | 1 | One-cycle pulse marking a newly arrived word |

## Verification
`src_busy` is due one source edge after acceptance and falls HOLD_CYCLES+GAP_CYCLES source edges later. `dst_data` and `dst_valid` change together on the (SYNC_STAGES+1)-th destination edge after the accepting source edge. The bench runs a behavioural model clocked by each domain's own edges and compares the outputs at the following falling edge of the same clock, so every result is read half a period after it is due. The two clock phases are chosen so that their rising edges never coincide. A directed latency check counts destination edges from the accepting source edge to the first `dst_valid`.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   // width of a counter that must hold the value n
   function automatic int cnt_w(input int n);
      int w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/mrs_src_ctrl.sv
module mrs_src_ctrl #(
   parameter int DATA_W      = 16,
   parameter int HOLD_CYCLES = 6,
   parameter int GAP_CYCLES  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              en,
   output logic [DATA_W-1:0] word
);
   localparam int TOTAL = HOLD_CYCLES + GAP_CYCLES;
   localparam int CW    = mrs_pkg::cnt_w(TOTAL);
   localparam logic [CW-1:0] HOLD_LIM  = CW'(HOLD_CYCLES);
   localparam logic [CW-1:0] TOTAL_LIM = CW'(TOTAL);

   logic [CW-1:0]     age_q;
   logic [CW-1:0]     age_nx;
   logic              busy_q;
   logic              en_q;
   logic [DATA_W-1:0] word_q;

   assign age_nx = age_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         age_q  <= '0;
         busy_q <= 1'b0;
         en_q   <= 1'b0;
         word_q <= '0;
      end else if (!busy_q) begin
         if (load) begin
            word_q <= data;
            en_q   <= 1'b1;
            busy_q <= 1'b1;
            age_q  <= '0;
         end
      end else begin
         age_q  <= age_nx;
         en_q   <= en_q && (age_nx < HOLD_LIM);
         busy_q <= (age_nx < TOTAL_LIM);
      end
   end

   assign busy = busy_q;
   assign en   = en_q;
   assign word = word_q;
endmodule

// File: rtl/mrs_sync_chain.sv
module mrs_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= 1'b0;
            else     stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= 1'b0;
            else     stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mrs_dst_capture.sv
module mrs_dst_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] data,
   output logic              valid
);
   logic sel_d;
   logic valid_q;

   // one recirculating mux plus flop per bit, all sharing one select
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic bit_q;
      logic bit_nx;
      assign bit_nx = sel ? bus[b] : bit_q;
      always_ff @(posedge clk) begin
         if (rst) bit_q <= 1'b0;
         else     bit_q <= bit_nx;
      end
      assign data[b] = bit_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_d   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         sel_d   <= sel;
         valid_q <= sel && !sel_d;
      end
   end

   assign valid = valid_q;
endmodule

// File: rtl/mux_recirc_bus_sync.sv
module mux_recirc_bus_sync #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 6,
   parameter int GAP_CYCLES  = 6
) (
   input  logic              src_clk,
   input  logic              src_rst,
   input  logic              src_load,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_busy,
   input  logic              dst_clk,
   input  logic              dst_rst,
   output logic [DATA_W-1:0] dst_data,
   output logic              dst_valid
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HOLD_CYCLES < 3 || GAP_CYCLES < 3) begin : g_bad_hold
      $error("HOLD_CYCLES and GAP_CYCLES must be at least 3");
   end

   logic              src_en_q;
   logic [DATA_W-1:0] src_word_q;
   logic              dst_en_s;

   mrs_src_ctrl #(
      .DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES), .GAP_CYCLES(GAP_CYCLES)
   ) u_src (
      .clk(src_clk), .rst(src_rst), .load(src_load), .data(src_data),
      .busy(src_busy), .en(src_en_q), .word(src_word_q)
   );

   mrs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(dst_clk), .rst(dst_rst), .d(src_en_q), .q(dst_en_s)
   );

   mrs_dst_capture #(.DATA_W(DATA_W)) u_dst (
      .clk(dst_clk), .rst(dst_rst), .sel(dst_en_s), .bus(src_word_q),
      .data(dst_data), .valid(dst_valid)
   );
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
   parameter int DATA_W = 16
) (
   input logic              src_clk,
   input logic              src_rst,
   input logic              src_busy,
   input logic              src_en,
   input logic [DATA_W-1:0] src_word,
   input logic              dst_clk,
   input logic              dst_rst,
   input logic              dst_en_s,
   input logic [DATA_W-1:0] dst_data,
   input logic              dst_valid
);
   a_r2_word_frozen: assert property (@(posedge src_clk) disable iff (src_rst)
      src_busy |=> $stable(src_word));

   a_r3_en_inside_busy: assert property (@(posedge src_clk) disable iff (src_rst)
      src_en |-> src_busy);

   a_r3_gap_after_en: assert property (@(posedge src_clk) disable iff (src_rst)
      $fell(src_en) |-> src_busy);

   a_r4_recirculate: assert property (@(posedge dst_clk) disable iff (dst_rst)
      !dst_en_s |=> $stable(dst_data));

   a_r5_valid_one_cycle: assert property (@(posedge dst_clk) disable iff (dst_rst)
      dst_valid |=> !dst_valid);

   a_r5_valid_while_sel: assert property (@(posedge dst_clk) disable iff (dst_rst)
      dst_valid |-> dst_en_s);

   a_r6_src_reset: assert property (@(posedge src_clk)
      src_rst |=> (!src_busy && !src_en && src_word == '0));

   a_r6_dst_reset: assert property (@(posedge dst_clk)
      dst_rst |=> (!dst_valid && !dst_en_s && dst_data == '0));
endmodule

bind mux_recirc_bus_sync mrs_checker #(.DATA_W(DATA_W)) u_chk (
   .src_clk(src_clk), .src_rst(src_rst), .src_busy(src_busy),
   .src_en(src_en_q), .src_word(src_word_q),
   .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_en_s(dst_en_s),
   .dst_data(dst_data), .dst_valid(dst_valid)
);

// File: tb/sim_mux_recirc_bus_sync.sv
`timescale 1ns/100ps
module sim_mux_recirc_bus_sync;
   localparam int DATA_W = 16;
   localparam int SYNC   = 2;
   localparam int HOLD   = 6;
   localparam int GAP    = 6;

   logic              src_clk = 1'b0, dst_clk = 1'b0;
   logic              src_rst = 1'b1, dst_rst = 1'b1;
   logic              src_load = 1'b0;
   logic [DATA_W-1:0] src_data = '0;
   logic              src_busy, dst_valid;
   logic [DATA_W-1:0] dst_data;

   int checks = 0, errors = 0;

   mux_recirc_bus_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC),
      .HOLD_CYCLES(HOLD), .GAP_CYCLES(GAP)) u0 (
      .src_clk(src_clk), .src_rst(src_rst), .src_load(src_load),
      .src_data(src_data), .src_busy(src_busy), .dst_clk(dst_clk),
      .dst_rst(dst_rst), .dst_data(dst_data), .dst_valid(dst_valid));

   // 200 MHz source clock; destination 7 ns, phase chosen so edges never meet
   always #2.5 src_clk = ~src_clk;
   initial begin
      #1.3;
      forever #3.5 dst_clk = ~dst_clk;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit                m_en, m_busy;
   int                m_age;
   logic [DATA_W-1:0] m_word;
   int                accepted = 0;
   bit                m_q[SYNC];
   bit                m_prev, m_valid;
   logic [DATA_W-1:0] m_data;
   bit                src_go = 0, dst_go = 0;
   int                valid_seen = 0;

   always @(posedge src_clk) begin
      src_go <= 1;
      if (src_rst) begin
         m_en = 0; m_busy = 0; m_age = 0; m_word = '0;
      end else if (!m_busy) begin
         if (src_load) begin
            m_word = src_data; m_en = 1; m_busy = 1; m_age = 0; accepted++;
         end
      end else begin
         m_age++;
         if (m_age >= HOLD) m_en = 0;
         if (m_age >= HOLD + GAP) m_busy = 0;
      end
   end

   always @(posedge dst_clk) begin
      dst_go <= 1;
      if (dst_rst) begin
         foreach (m_q[i]) m_q[i] = 0;
         m_prev = 0; m_valid = 0; m_data = '0;
      end else begin
         m_valid = m_q[SYNC-1] && !m_prev;
         m_prev  = m_q[SYNC-1];
         if (m_q[SYNC-1]) m_data = m_word;
         for (int i = SYNC-1; i > 0; i--) m_q[i] = m_q[i-1];
         m_q[0] = m_en;
      end
   end

   always @(negedge src_clk) if (src_go)
      check(src_busy === m_busy, "R3 busy vs model", src_busy, m_busy);

   always @(negedge dst_clk) if (dst_go) begin
      check(dst_data === m_data, "R4 dst_data vs model", dst_data, m_data);
      check(dst_valid === m_valid, "R5 dst_valid vs model", dst_valid, m_valid);
      if (!dst_rst && dst_valid === 1'b1) valid_seen++;
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [DATA_W-1:0] d);
      @(negedge src_clk);
      while (src_busy) @(negedge src_clk);
      src_data = d; src_load = 1'b1;
      @(negedge src_clk);
      src_load = 1'b0;
      check(src_busy === 1'b1, "R1 busy after accept", src_busy, 1);
   endtask

   task automatic wait_idle();
      @(negedge src_clk);
      while (src_busy) @(negedge src_clk);
      repeat (4) @(negedge dst_clk);
   endtask

   initial begin
      int n;
      int busy_len;
      int v0;
      logic [DATA_W-1:0] pats[5] = '{16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h0F0F};

      repeat (6) @(negedge src_clk);
      src_rst = 1'b0; dst_rst = 1'b0;
      @(negedge src_clk);
      check(src_busy === 1'b0, "R6 busy after reset", src_busy, 0);
      @(negedge dst_clk);
      check(dst_data === '0, "R6 dst_data after reset", dst_data, 0);
      check(dst_valid === 1'b0, "R6 dst_valid after reset", dst_valid, 0);

      // single word
      send(16'hA5C3);
      wait_idle();
      check(dst_data === 16'hA5C3, "R1 word delivered", dst_data, 16'hA5C3);

      // loads while busy are ignored
      send(16'h1234);
      src_data = 16'hFFFF; src_load = 1'b1;
      repeat (4) @(negedge src_clk);
      src_load = 1'b0;
      wait_idle();
      check(dst_data === 16'h1234, "R2 busy load ignored", dst_data, 16'h1234);

      // busy duration
      @(negedge src_clk);
      src_data = 16'h3C3C; src_load = 1'b1;
      @(negedge src_clk);
      src_load = 1'b0;
      busy_len = 0;
      while (src_busy && busy_len < 100) begin busy_len++; @(negedge src_clk); end
      check(busy_len == HOLD + GAP, "R3 busy length", busy_len, HOLD + GAP);
      wait_idle();

      // latency from accepting edge to valid
      @(negedge src_clk);
      src_data = 16'hBEEF; src_load = 1'b1;
      @(posedge src_clk);
      n = 0;
      do begin
         @(posedge dst_clk); n++;
         @(negedge dst_clk);
      end while (dst_valid !== 1'b1 && n < 50);
      src_load = 1'b0;
      check(n == SYNC + 1, "R5 latency in dst edges", n, SYNC + 1);
      check(dst_data === 16'hBEEF, "R5 data with valid", dst_data, 16'hBEEF);
      @(negedge dst_clk);
      check(dst_valid === 1'b0, "R5 valid one cycle", dst_valid, 0);
      wait_idle();

      // back-to-back patterns, ordering and pulse count
      v0 = valid_seen;
      foreach (pats[k]) begin
         send(pats[k]);
         wait_idle();
         check(dst_data === pats[k], "R7 in-order word", dst_data, pats[k]);
      end
      check(valid_seen - v0 == 5, "R7 one valid per word", valid_seen - v0, 5);
      check(valid_seen == accepted, "R7 total valids", valid_seen, accepted);

      // destination reset alone
      @(negedge dst_clk); dst_rst = 1'b1;
      repeat (3) @(negedge dst_clk);
      dst_rst = 1'b0;
      check(dst_data === '0, "R6 dst reset clears data", dst_data, 0);
      check(dst_valid === 1'b0, "R6 dst reset clears valid", dst_valid, 0);
      send(16'h7E81);
      wait_idle();
      check(dst_data === 16'h7E81, "R1 word after dst reset", dst_data, 16'h7E81);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge src_clk);
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule